// File: doc/BRIEF.md
# Wrap-Safe Microsecond Delay Engine

This block times a busy-wait delay without owning a timer of its own. It watches a free-running cycle counter that some other part of the chip drives and that it shares with other users. A start pulse arrives with a delay length in microseconds. The engine turns that length into a target tick count, using a parameter that gives the number of core clocks per microsecond. It takes the counter value at the moment of the start as its reference. From then on it adds up the ticks between successive counter samples until the total reaches the target.

Each counter step is taken modulo the counter width, so a wrap of the counter from its top value back through zero loses no ticks. The counter does not have to advance by one per clock, and it may stall, because only a change in the sampled value adds to the total. `busy_o` is high while a delay is running. `done_o` pulses for one cycle when the delay ends, and the engine then returns to idle.

Top module: `us_delay_engine`

## Requirements
- R1: The target tick count is the requested microseconds `us_i` multiplied by the parameter `CLK_PER_US`.
- R2: A request above the parameter `MAX_US` is treated as exactly `MAX_US`, which gives a target of `MAX_US*CLK_PER_US` ticks.
- R3: On the clock edge that accepts `start_i`, `cnt_i` is captured as the reference and the elapsed total is cleared. Counter movement before that edge does not count. `busy_o` is high from that edge on.
- R4: On an edge where the sampled `cnt_i` equals the reference, nothing is added to the elapsed total. When `cnt_i` differs from the reference, it becomes the new reference.
- R5: Each increment is `(cnt_i - reference) mod 2^CNT_W`. A wrap of the counter through zero therefore adds exactly the number of ticks that passed.
- R6: On the first edge at which the elapsed total, including that edge's increment, is greater than or equal to the target, `done_o` goes high and `busy_o` goes low.
- R7: A request of 0 us completes on the first edge after the accepting edge.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. It does not change the target, the reference or the completion time of the running delay.
- R9: `done_o` is high for exactly one cycle, and the engine is then idle with `busy_o` low until the next accepted start.
- R10: While `rst_ni` is low, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a delay; accepted only while idle |
| us_i | input | US_W | Requested delay in microseconds, sampled with `start_i` |
| cnt_i | input | CNT_W | Free-running shared cycle counter |
| busy_o | output | 1 | A delay is running |
| done_o | output | 1 | One-cycle pulse when the delay has elapsed |

## Verification
Two conditions are hard to create with a counter that runs freely: a wrap through zero in the middle of a delay, and a clamped request. The counter is an input, so the bench drives it directly. It can place the start a few ticks below the top of the counter range, advance the counter by any step each cycle, and hold it still to create stalls. With a small clock ratio in the bench, a clamped request and a request at exactly the limit each finish within a few thousand cycles. Their completion cycles differ from that of a request just below the limit, so clamping shows up in the cycle counts.

// File: rtl/dly_pkg.sv
package dly_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dly_state_e;
endpackage

// File: rtl/dly_target_conv.sv
module dly_target_conv #(
  parameter int unsigned US_W       = 32,
  parameter int unsigned TGT_W      = 32,
  parameter int unsigned CLK_PER_US = 100,
  parameter int unsigned MAX_US     = 8_000_000
) (
  input  logic [US_W-1:0]  us_i,
  output logic [TGT_W-1:0] tgt_o
);
  localparam logic [US_W-1:0]  US_LIM = US_W'(MAX_US);
  localparam logic [TGT_W-1:0] MULT   = TGT_W'(CLK_PER_US);

  logic [US_W-1:0]  us_lim;
  logic [TGT_W-1:0] us_ext;

  // clamp before the multiply so the product always fits TGT_W
  assign us_lim = (us_i > US_LIM) ? US_LIM : us_i;
  assign us_ext = TGT_W'(us_lim);
  assign tgt_o  = us_ext * MULT;
endmodule

// File: rtl/dly_tick_accum.sv
module dly_tick_accum #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W:0]   acc_sum_o
);
  localparam int unsigned ACC_W = CNT_W + 1;

  logic [CNT_W-1:0] ref_q;
  logic [ACC_W-1:0] acc_q;
  logic             moved;
  logic [CNT_W-1:0] inc;

  assign moved     = (cnt_i != ref_q);
  // modular difference covers the wrap through zero
  assign inc       = moved ? (cnt_i - ref_q) : '0;
  assign acc_sum_o = acc_q + ACC_W'(inc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      ref_q <= cnt_i;
      acc_q <= '0;
    end else if (run_i) begin
      if (moved) ref_q <= cnt_i;
      acc_q <= acc_sum_o;
    end
  end

  p_stall_no_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !moved) |=> (acc_q == $past(acc_q)));

  p_ref_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> (ref_q == $past(cnt_i)));

  p_acc_monotonic_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i) |=> (acc_q >= $past(acc_q)));

  p_load_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (acc_q == '0 && ref_q == $past(cnt_i)));
endmodule

// File: rtl/dly_ctrl.sv
module dly_ctrl
  import dly_pkg::*;
#(
  parameter int unsigned TGT_W = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TGT_W-1:0] tgt_i,
  input  logic [CNT_W:0]   acc_sum_i,
  output logic             load_o,
  output logic             run_o,
  output logic             busy_o,
  output logic             done_o
);
  dly_state_e       state_q;
  logic [TGT_W-1:0] tgt_q;
  logic             done_q;
  logic             hit;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign run_o  = (state_q == ST_RUN);
  assign hit    = (acc_sum_i >= (CNT_W+1)'(tgt_q));
  assign busy_o = run_o;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tgt_q   <= tgt_i;
          state_q <= ST_RUN;
        end
        ST_RUN: if (hit) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_busy_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_zero_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && tgt_i == '0) |=> ##1 done_o);

  p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(tgt_q));
endmodule

// File: rtl/us_delay_engine.sv
module us_delay_engine #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned US_W       = 32,
  parameter int unsigned CLK_PER_US = 100,
  parameter int unsigned MAX_US     = 8_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [US_W-1:0]  us_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned TGT_W = CNT_W;

  logic [TGT_W-1:0] tgt;
  logic [CNT_W:0]   acc_sum;
  logic             load;
  logic             run;

  dly_target_conv #(
    .US_W       (US_W),
    .TGT_W      (TGT_W),
    .CLK_PER_US (CLK_PER_US),
    .MAX_US     (MAX_US)
  ) u_conv (
    .us_i  (us_i),
    .tgt_o (tgt)
  );

  dly_tick_accum #(
    .CNT_W (CNT_W)
  ) u_accum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .run_i     (run),
    .cnt_i     (cnt_i),
    .acc_sum_o (acc_sum)
  );

  dly_ctrl #(
    .TGT_W (TGT_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tgt_i     (tgt),
    .acc_sum_i (acc_sum),
    .load_o    (load),
    .run_o     (run),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  p_reset_quiet_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (!busy_o && !done_o));
endmodule

// File: tb/us_delay_engine_bench.sv
module us_delay_engine_bench;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned US_W  = 32;
  localparam int unsigned CPU   = 4;
  localparam int unsigned MAXU  = 1000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [US_W-1:0]  us = '0;
  logic [CNT_W-1:0] cnt = '0;
  logic             busy;
  logic             done;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  us_delay_engine #(
    .CNT_W (CNT_W), .US_W (US_W), .CLK_PER_US (CPU), .MAX_US (MAXU)
  ) u_us_delay_engine (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .us_i (us),
    .cnt_i (cnt), .busy_o (busy), .done_o (done)
  );

  // {us, start count, step per cycle, expected edges to done}
  localparam logic [127:0] VEC [10] = '{
    {32'd5,    32'd100,         32'd1,    32'd20},   // R1 R6
    {32'd5,    32'd100,         32'd3,    32'd7},    // R1 R6 coarse steps
    {32'd0,    32'd7,           32'd1,    32'd1},    // R7
    {32'd10,   32'hFFFF_FFF0,   32'd5,    32'd8},    // R5 wrap mid-delay
    {32'd2,    32'hFFFF_FFFF,   32'd8,    32'd1},    // R5 single-step wrap
    {32'd3,    32'd500,         32'd11,   32'd2},    // R6 overshoot
    {32'd5000, 32'd0,           32'd1,    32'd4000}, // R2 clamped
    {32'd1000, 32'd9,           32'd1,    32'd4000}, // R2 at limit
    {32'd999,  32'd9,           32'd1,    32'd3996}, // R1 below limit
    {32'd7,    32'hFFFF_FF00,   32'd256,  32'd1}     // R5 jump to zero
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [31:0] u, input logic [31:0] c0,
                          input logic [31:0] step, input int exp, input string req);
    int  n;
    bit  busy_ok;
    @(negedge clk);
    cnt = c0 - 32'd1234;            // movement before start must not count (R3)
    @(negedge clk);
    us = u; cnt = c0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R3 busy after accept", busy, 1);
    n = 0; busy_ok = 1'b1;
    while (n < 6000) begin
      cnt = cnt + step;
      @(negedge clk);
      n++;
      if (done) break;
      if (!busy) busy_ok = 1'b0;
    end
    check(n == exp, req, n, exp);
    check(busy_ok && !busy, "R6 busy until done", busy, 0);
    @(negedge clk);
    check(!done && !busy, "R9 single done pulse", done, 0);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    bit early;
    // R10 reset state
    start = 1'b1; us = 32'd3;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R10 reset quiet", busy, 0);
    start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) begin
      run_case(VEC[i][127:96], VEC[i][95:64], VEC[i][63:32], int'(VEC[i][31:0]),
               $sformatf("R1 R2 R5 R6 vector %0d edges", i));
    end

    // R4 stalled counter adds nothing
    @(negedge clk);
    us = 32'd1; cnt = 32'd50; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    early = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (done || !busy) early = 1'b1;
    end
    check(!early, "R4 stall no progress", early, 0);
    cnt = 32'd53;
    @(negedge clk);
    check(!done && busy, "R4 partial progress", done, 0);
    cnt = 32'd54;
    @(negedge clk);
    check(done && !busy, "R4 completes on change", done, 1);
    @(negedge clk);

    // R8 start while busy ignored (zero request would finish at once)
    us = 32'd2; cnt = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (n < 100) begin
      cnt = cnt + 32'd1;
      if (n == 2) begin us = 32'd0; start = 1'b1; end
      else start = 1'b0;
      @(negedge clk);
      n++;
      if (done) break;
    end
    start = 1'b0;
    check(n == 8, "R8 start ignored while busy", n, 8);
    @(negedge clk);
    check(!done && !busy, "R9 idle after done", busy, 0);

    // R7 back-to-back zero request right after done
    us = 32'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R7 zero accepted", busy, 1);
    @(negedge clk);
    check(done && !busy, "R7 zero completes", done, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule